// File: doc/BRIEF.md
# Disk Channel Control and Status Register Block

This block holds the software-visible control and status registers for the command channels of a descriptor-driven disk controller. A host reaches it over a simple 16-bit memory-mapped bus that has a write strobe, a read strobe and a byte address. Read data is returned combinationally in the same cycle as the read strobe. Each channel owns a 32-byte register window. Channel n starts at byte address 0x80 + 0x20·n. The default build has two channels.

Each channel drives its command engine through three signals:
- a one-cycle start pulse;
- a level-held engine reset;
- the configured command-block count, next-command-block pointer, FIFO thresholds and PIO timing mode.

The engine reports three kinds of event back to the channel. The channel latches them as sticky status flags, and a read of the status register clears them. Each channel raises its own interrupt while any flag is held and its interrupt mask is clear.

One global unlock register sits outside the channel windows. Until software writes the unlock value there, every start request is dropped.

Top module: `dchan_regs`

## Requirements
- R1: After reset every channel register reads 0, and irq, eng_start and eng_reset are all low.
- R2: Offsets inside a channel window are:
  - control at 0x00 and status at 0x02;
  - command-block count at 0x04;
  - pointer low half at 0x0C and pointer high half at 0x0E;
  - input FIFO threshold at 0x14 and output FIFO threshold at 0x16.

  Any other offset, and any address outside all windows, reads 0.
- R3: Starts are enabled only after a write whose low data byte is 0x07 lands on address 0xC7. A write of any other value there leaves starts disabled. Once enabled, starts stay enabled until reset.
- R4: Writing the control register with bit 7 set produces a single-cycle eng_start pulse in the cycle after the write. This happens only if starts are enabled and bit 5 of that same write is 0. Bit 7 is not stored, so a control read returns 0 there.
- R5: eng_reset equals control bit 5 and stays high until a control write clears that bit.
- R6: Each event input latches into its own status bit, visible the cycle after the pulse, and stays set while the status register is not read. The packet-state event sets bit 6, the unexpected-interrupt event sets bit 4, and the host-error event sets bit 0.
- R7: A status read returns the flags held before the read and then clears them. An event arriving in the same cycle as the read stays set.
- R8: irq is high exactly when at least one status flag is set and control bit 8 (the mask) is 0.
- R9: The 32-bit next-command-block pointer is written as two 16-bit halves. Bits 2:0 of the low half are forced to 0, so the pointer is always 8-byte aligned. The pointer appears on cb_next_ptr.
- R10: The command-block count and both FIFO thresholds store and read back all 16 bits, and each is driven on its own output.
- R11: A control read shows the mask in bit 8, the reset in bit 5 and the PIO mode in bits 1:0, with every other bit 0. The PIO mode is also driven on pio_mode; mode 4 is the code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| evt_pkt | input | 2 | Packet-state event per channel |
| evt_unexp | input | 2 | Unexpected-interrupt event per channel |
| evt_herr | input | 2 | Host bus error event per channel |
| eng_start | output | 2 | Start pulse per channel |
| eng_reset | output | 2 | Engine reset level per channel |
| irq | output | 2 | Masked interrupt per channel |
| pio_mode | output | 4 | PIO mode, 2 bits per channel |
| cb_count | output | 32 | Command-block count, 16 bits per channel |
| cb_next_ptr | output | 64 | Next command-block pointer, 32 bits per channel |
| fifo_in_thr | output | 32 | Input FIFO threshold per channel |
| fifo_out_thr | output | 32 | Output FIFO threshold per channel |

## Verification
The assertions check four things on every cycle:
- the unlock state never falls back;
- a start pulse never appears while the lock is closed or engine reset is held;
- a status flag never drops except on a status read;
- an unmasked event always raises irq on the next cycle.

Only the bench scenarios can show the rest:
- the address map and the read-back values;
- the rule that a wrong unlock value is refused;
- the old value returned on a read that collides with an event;
- pointer alignment;
- the random mix of writes, events and status reads compared against a reference model.

// File: rtl/dchan_pkg.sv
package dchan_pkg;
    localparam int BUS_W   = 16;
    localparam int OFF_W   = 5;
    localparam int PTR_W   = 32;
    localparam int MODE_W  = 2;
    localparam int EVT_W   = 3;

    localparam logic [OFF_W-1:0] OFF_CTRL   = 5'h00;
    localparam logic [OFF_W-1:0] OFF_STAT   = 5'h02;
    localparam logic [OFF_W-1:0] OFF_COUNT  = 5'h04;
    localparam logic [OFF_W-1:0] OFF_PTR_LO = 5'h0C;
    localparam logic [OFF_W-1:0] OFF_PTR_HI = 5'h0E;
    localparam logic [OFF_W-1:0] OFF_FIN    = 5'h14;
    localparam logic [OFF_W-1:0] OFF_FOUT   = 5'h16;

    localparam int CTL_MASK_BIT  = 8;
    localparam int CTL_GO_BIT    = 7;
    localparam int CTL_RST_BIT   = 5;

    // event vector order: [2] packet-state, [1] unexpected irq, [0] host error
    localparam int STAT_PKT_BIT  = 6;
    localparam int STAT_UNX_BIT  = 4;
    localparam int STAT_HERR_BIT = 0;

    typedef struct packed {
        logic              mask;
        logic              rst;
        logic [MODE_W-1:0] mode;
        logic              start;
        logic [EVT_W-1:0]  stat;
        logic [BUS_W-1:0]  count;
        logic [PTR_W-1:0]  ptr;
        logic [BUS_W-1:0]  fin;
        logic [BUS_W-1:0]  fout;
    } chan_state_t;
endpackage

// File: rtl/dchan_lock.sv
module dchan_lock
    import dchan_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  LOCK_ADDR = 8'hC7,
    parameter logic [7:0]  LOCK_KEY  = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        key_i,
    output logic              open_o
);
    logic lock_d, lock_q;

    always_comb begin
        lock_d = lock_q;
        if (wr_i && addr_i == ADDR_W'(LOCK_ADDR) && key_i == LOCK_KEY)
            lock_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= lock_d;
    end

    assign open_o = lock_q;

    assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);
endmodule

// File: rtl/dchan_chan_regs.sv
module dchan_chan_regs
    import dchan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic              lock_i,
    input  logic [EVT_W-1:0]  evt_i,
    output logic [BUS_W-1:0]  rdata_o,
    output logic              start_o,
    output logic              reset_o,
    output logic              irq_o,
    output logic [MODE_W-1:0] mode_o,
    output logic [BUS_W-1:0]  count_o,
    output logic [PTR_W-1:0]  ptr_o,
    output logic [BUS_W-1:0]  fin_o,
    output logic [BUS_W-1:0]  fout_o
);
    localparam int HALF_W  = PTR_W / 2;
    localparam int ALIGN_W = 3;

    chan_state_t s_d, s_q;
    logic        wr_hit, rd_stat, ctrl_wr;
    logic [BUS_W-1:0] r;

    assign wr_hit  = sel_i & wr_i;
    assign ctrl_wr = wr_hit & (off_i == OFF_CTRL);
    assign rd_stat = sel_i & rd_i & (off_i == OFF_STAT);

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        if (rd_stat) s_d.stat = '0;
        s_d.stat = s_d.stat | evt_i;
        if (wr_hit) begin
            case (off_i)
                OFF_CTRL: begin
                    s_d.mask  = wdata_i[CTL_MASK_BIT];
                    s_d.rst   = wdata_i[CTL_RST_BIT];
                    s_d.mode  = wdata_i[MODE_W-1:0];
                    s_d.start = wdata_i[CTL_GO_BIT] & ~wdata_i[CTL_RST_BIT] & lock_i;
                end
                OFF_COUNT:  s_d.count = wdata_i;
                OFF_PTR_LO: s_d.ptr[HALF_W-1:0] = {wdata_i[HALF_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
                OFF_PTR_HI: s_d.ptr[PTR_W-1:HALF_W] = wdata_i;
                OFF_FIN:    s_d.fin  = wdata_i;
                OFF_FOUT:   s_d.fout = wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        r = '0;
        case (off_i)
            OFF_CTRL: begin
                r[CTL_MASK_BIT]   = s_q.mask;
                r[CTL_RST_BIT]    = s_q.rst;
                r[MODE_W-1:0]     = s_q.mode;
            end
            OFF_STAT: begin
                r[STAT_PKT_BIT]   = s_q.stat[2];
                r[STAT_UNX_BIT]   = s_q.stat[1];
                r[STAT_HERR_BIT]  = s_q.stat[0];
            end
            OFF_COUNT:  r = s_q.count;
            OFF_PTR_LO: r = s_q.ptr[HALF_W-1:0];
            OFF_PTR_HI: r = s_q.ptr[PTR_W-1:HALF_W];
            OFF_FIN:    r = s_q.fin;
            OFF_FOUT:   r = s_q.fout;
            default:    r = '0;
        endcase
        rdata_o = sel_i ? r : '0;
    end

    assign start_o = s_q.start;
    assign reset_o = s_q.rst;
    assign irq_o   = (|s_q.stat) & ~s_q.mask;
    assign mode_o  = s_q.mode;
    assign count_o = s_q.count;
    assign ptr_o   = s_q.ptr;
    assign fin_o   = s_q.fin;
    assign fout_o  = s_q.fout;

    assert_start_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> (lock_i && !reset_o));

    assert_event_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((s_q.stat & $past(evt_i)) == $past(evt_i)));

    assert_stat_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stat |=> ((s_q.stat & $past(s_q.stat)) == $past(s_q.stat)));

    assert_irq_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.mask && (|evt_i) && !ctrl_wr) |=> irq_o);
endmodule

// File: rtl/dchan_regs.sv
module dchan_regs
    import dchan_pkg::*;
#(
    parameter int         NUM_CH    = 2,
    parameter int         ADDR_W    = 8,
    parameter logic [7:0] CH_BASE   = 8'h80,
    parameter logic [7:0] LOCK_ADDR = 8'hC7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [BUS_W-1:0]           bus_wdata,
    output logic [BUS_W-1:0]           bus_rdata,
    input  logic [NUM_CH-1:0]          evt_pkt,
    input  logic [NUM_CH-1:0]          evt_unexp,
    input  logic [NUM_CH-1:0]          evt_herr,
    output logic [NUM_CH-1:0]          eng_start,
    output logic [NUM_CH-1:0]          eng_reset,
    output logic [NUM_CH-1:0]          irq,
    output logic [NUM_CH*MODE_W-1:0]   pio_mode,
    output logic [NUM_CH*BUS_W-1:0]    cb_count,
    output logic [NUM_CH*PTR_W-1:0]    cb_next_ptr,
    output logic [NUM_CH*BUS_W-1:0]    fifo_in_thr,
    output logic [NUM_CH*BUS_W-1:0]    fifo_out_thr
);
    localparam int WIN_W   = ADDR_W - OFF_W;
    localparam int BASE_IX = int'(CH_BASE) >> OFF_W;

    logic                 lock_open;
    logic [BUS_W-1:0]     ch_rdata [NUM_CH];

    dchan_lock #(.ADDR_W(ADDR_W), .LOCK_ADDR(LOCK_ADDR), .LOCK_KEY(8'h07)) i_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (bus_wr),
        .addr_i (bus_addr),
        .key_i  (bus_wdata[7:0]),
        .open_o (lock_open)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic ch_sel;
        assign ch_sel = (bus_addr[ADDR_W-1:OFF_W] == WIN_W'(BASE_IX + g));

        dchan_chan_regs i_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel_i   (ch_sel),
            .wr_i    (bus_wr),
            .rd_i    (bus_rd),
            .off_i   (bus_addr[OFF_W-1:0]),
            .wdata_i (bus_wdata),
            .lock_i  (lock_open),
            .evt_i   ({evt_pkt[g], evt_unexp[g], evt_herr[g]}),
            .rdata_o (ch_rdata[g]),
            .start_o (eng_start[g]),
            .reset_o (eng_reset[g]),
            .irq_o   (irq[g]),
            .mode_o  (pio_mode[g*MODE_W +: MODE_W]),
            .count_o (cb_count[g*BUS_W +: BUS_W]),
            .ptr_o   (cb_next_ptr[g*PTR_W +: PTR_W]),
            .fin_o   (fifo_in_thr[g*BUS_W +: BUS_W]),
            .fout_o  (fifo_out_thr[g*BUS_W +: BUS_W])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) bus_rdata = bus_rdata | ch_rdata[i];
    end
endmodule

// File: tb/test_dchan_regs.sv
module test_dchan_regs;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  evt_pkt = '0, evt_unexp = '0, evt_herr = '0;
    logic [1:0]  eng_start, eng_reset, irq;
    logic [3:0]  pio_mode;
    logic [31:0] cb_count, fifo_in_thr, fifo_out_thr;
    logic [63:0] cb_next_ptr;

    int checks = 0, errors = 0;
    bit done = 0;

    logic        m_mask [2];
    logic        m_rst  [2];
    logic [1:0]  m_mode [2];
    logic [2:0]  m_stat [2];
    logic [15:0] m_cnt [2], m_fin [2], m_fout [2];
    logic [31:0] m_ptr [2];

    always #4 clk = ~clk;

    dchan_regs i_dchan_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_pkt(evt_pkt), .evt_unexp(evt_unexp), .evt_herr(evt_herr),
        .eng_start(eng_start), .eng_reset(eng_reset), .irq(irq),
        .pio_mode(pio_mode), .cb_count(cb_count), .cb_next_ptr(cb_next_ptr),
        .fifo_in_thr(fifo_in_thr), .fifo_out_thr(fifo_out_thr)
    );

    function automatic logic [7:0] ca(int ch, logic [7:0] off);
        return 8'h80 + 8'(ch * 32) + off;
    endfunction

    function automatic logic [15:0] exp_ctrl(int ch);
        logic [15:0] v = '0;
        v[8] = m_mask[ch]; v[5] = m_rst[ch]; v[1:0] = m_mode[ch];
        return v;
    endfunction

    function automatic logic [15:0] exp_stat(int ch);
        logic [15:0] v = '0;
        v[6] = m_stat[ch][2]; v[4] = m_stat[ch][1]; v[0] = m_stat[ch][0];
        return v;
    endfunction

    function automatic logic exp_irq(int ch);
        return (|m_stat[ch]) & ~m_mask[ch];
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [15:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic evt(int ch, logic [2:0] b);
        evt_pkt[ch] = b[2]; evt_unexp[ch] = b[1]; evt_herr[ch] = b[0];
        @(negedge clk);
        evt_pkt = '0; evt_unexp = '0; evt_herr = '0;
        m_stat[ch] = m_stat[ch] | b;
    endtask

    task automatic rd_stat_evt(int ch, logic [2:0] b, output logic [15:0] d);
        evt_pkt[ch] = b[2]; evt_unexp[ch] = b[1]; evt_herr[ch] = b[0];
        rd(ca(ch, 8'h02), d);
        evt_pkt = '0; evt_unexp = '0; evt_herr = '0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [15:0] d;
        void'($urandom(32'd20240611));
        for (int c = 0; c < 2; c++) begin
            m_mask[c] = 0; m_rst[c] = 0; m_mode[c] = 0; m_stat[c] = 0;
            m_cnt[c] = 0; m_fin[c] = 0; m_fout[c] = 0; m_ptr[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int c = 0; c < 2; c++) begin
            foreach (m_cnt[k]) begin end
            for (int o = 0; o < 32; o += 2) begin
                rd(ca(c, 8'(o)), d);
                chk("R1 reset readback", d, 0);
            end
        end
        chk("R1 outputs idle", {irq, eng_start, eng_reset}, 0);

        // R2 unmapped addresses
        rd(8'h10, d);        chk("R2 below window", d, 0);
        rd(ca(0, 8'h10), d); chk("R2 lookup offset", d, 0);
        rd(8'hC6, d);        chk("R2 outside windows", d, 0);

        // R4 start before unlock is dropped
        wr(ca(0, 8'h00), 16'h0083); m_mode[0] = 2'd3;
        chk("R4 locked start", eng_start, 0);
        chk("R11 pio mode out", pio_mode[1:0], 2'd3);
        // R3 wrong key
        wr(8'hC7, 16'h0005);
        wr(ca(0, 8'h00), 16'h0083);
        chk("R3 wrong key keeps lock", eng_start, 0);
        wr(8'hC7, 16'h0007);
        wr(ca(0, 8'h00), 16'h0083);
        chk("R3 R4 start pulse", eng_start, 2'b01);
        @(negedge clk);
        chk("R4 pulse one cycle", eng_start, 0);
        rd(ca(0, 8'h00), d);
        chk("R11 R4 ctrl readback", d, 16'h0003);

        // R5 reset bit blocks start
        wr(ca(1, 8'h00), 16'h00A3); m_rst[1] = 1; m_mode[1] = 3;
        chk("R4 start with reset ignored", eng_start, 0);
        chk("R5 engine reset held", eng_reset, 2'b10);
        @(negedge clk);
        chk("R5 reset still held", eng_reset, 2'b10);
        wr(ca(1, 8'h00), 16'h0003); m_rst[1] = 0;
        chk("R5 reset released", eng_reset, 0);

        // R6 R7 R8 status and irq
        evt(1, 3'b001);
        chk("R8 irq from host error", irq, 2'b10);
        rd(ca(1, 8'h02), d);
        chk("R6 status herr bit", d, 16'h0001);
        m_stat[1] = 0;
        chk("R7 irq clears after read", irq, 0);
        rd(ca(1, 8'h02), d);
        chk("R7 status cleared", d, 0);
        evt(0, 3'b110);
        rd_stat_evt(0, 3'b001, d);
        chk("R7 read returns old flags", d, 16'h0050);
        m_stat[0] = 3'b001;
        rd(ca(0, 8'h02), d);
        chk("R7 collision event kept", d, 16'h0001);
        m_stat[0] = 0;

        // R8 mask
        wr(ca(1, 8'h00), 16'h0100); m_mask[1] = 1; m_mode[1] = 0;
        evt(1, 3'b010);
        chk("R8 masked irq low", irq, 0);
        wr(ca(1, 8'h00), 16'h0000); m_mask[1] = 0;
        chk("R8 unmasked irq high", irq, 2'b10);
        rd(ca(1, 8'h02), d);
        chk("R6 unexp bit", d, 16'h0010);
        m_stat[1] = 0;

        // R9 pointer alignment
        wr(ca(0, 8'h0C), 16'hABCF); m_ptr[0][15:0] = 16'hABC8;
        wr(ca(0, 8'h0E), 16'h1234); m_ptr[0][31:16] = 16'h1234;
        rd(ca(0, 8'h0C), d); chk("R9 low half aligned", d, 16'hABC8);
        chk("R9 pointer out", cb_next_ptr[31:0], 32'h1234ABC8);

        // random mix
        for (int it = 0; it < 400; it++) begin
            int c = int'($urandom_range(0, 1));
            int op = int'($urandom_range(0, 7));
            logic [15:0] v = 16'($urandom);
            case (op)
                0: begin wr(ca(c, 8'h04), v); m_cnt[c] = v;
                   rd(ca(c, 8'h04), d); chk("R10 count", d, m_cnt[c]);
                   chk("R10 count out", cb_count[c*16 +: 16], m_cnt[c]); end
                1: begin wr(ca(c, 8'h14), v); m_fin[c] = v;
                   rd(ca(c, 8'h14), d); chk("R10 fifo in", d, m_fin[c]);
                   chk("R10 fifo in out", fifo_in_thr[c*16 +: 16], m_fin[c]); end
                2: begin wr(ca(c, 8'h16), v); m_fout[c] = v;
                   rd(ca(c, 8'h16), d); chk("R10 fifo out", d, m_fout[c]);
                   chk("R10 fifo out out", fifo_out_thr[c*16 +: 16], m_fout[c]); end
                3: begin
                   if (v[0]) begin wr(ca(c, 8'h0C), v); m_ptr[c][15:0] = {v[15:3], 3'b000}; end
                   else begin wr(ca(c, 8'h0E), v); m_ptr[c][31:16] = v; end
                   chk("R9 pointer", cb_next_ptr[c*32 +: 32], m_ptr[c]); end
                4: begin
                   logic [1:0] es = '0;
                   wr(ca(c, 8'h00), v);
                   m_mask[c] = v[8]; m_rst[c] = v[5]; m_mode[c] = v[1:0];
                   es[c] = v[7] & ~v[5];
                   chk("R4 random start", eng_start, es);
                   chk("R5 random reset", eng_reset[c], m_rst[c]);
                   rd(ca(c, 8'h00), d); chk("R11 ctrl", d, exp_ctrl(c)); end
                5, 6: begin evt(c, v[2:0]); end
                default: begin
                   rd_stat_evt(c, v[6:4], d);
                   chk("R7 random status read", d, exp_stat(c));
                   m_stat[c] = v[6:4]; end
            endcase
            chk("R8 random irq", irq, {exp_irq(1), exp_irq(0)});
        end
        done = 1;
        summary();
    end
endmodule